// File: doc/BRIEF.md
# Programmable Periodic Wake-Up Timer

This block raises a periodic wake-up interrupt from a slow oscillator clock of roughly 1 kHz. The block runs entirely in that clock domain.

A prescaler divides the oscillator clock into a wake-up tick. The tick period is `BASE_CYC + STEP_CYC × divider` oscillator cycles. The defaults are 504 and 16, which give 1.000 s at the reset divider of 0x1F. A tick counter then counts ticks up to a programmed interval of 1 to 255. When it reaches the interval, the counter sets a sticky interrupt flag, which software clears by writing one.

Both settings live in 8-bit registers on a simple single-cycle register bus. The interval register has guarded write rules:

- A changed value restarts the timing.
- A repeated value is ignored.
- An all-zero write disables the interrupt.
- The all-zero write is refused when an external input reports that the companion periodic-reset count is already zero. This keeps at least one of the two mechanisms armed.

Top module: `pwu_timer`

## Requirements
- R1: The divider register is 8 bits, accepts any value 0x00–0xFF, reads back the value last written, and resets to 0x1F.
- R2: The wake-up tick period is `BASE_CYC + STEP_CYC × div` clock cycles. A divider write takes effect at the next tick boundary (or restart) and does not restart the interval count.
- R3: After reset the interval register reads 0xFF with the interrupt enabled. The interrupt flag rises on the `P×N`-th rising edge after reset release or after a restart, where P is the tick period and N the interval.
- R4: Writing a non-zero interval value that differs from the current one restarts both the prescaler and the tick count. The restart takes effect at the write edge.
- R5: Writing the value the interval register already holds, while enabled, is ignored, and the count runs on undisturbed.
- R6: An all-zero interval write with `prst_cnt_zero_i`=0 forces the interval register to 0xFF and clears the enable (status bit 1). No interrupt is then raised.
- R7: An all-zero interval write with `prst_cnt_zero_i`=1 is refused: register, enable and count are all unchanged.
- R8: Any non-zero interval write while disabled, including 0xFF, re-enables the interrupt and restarts timing.
- R9: The interrupt flag is sticky. Writing status with bit 0 = 1 clears it, and writing bit 0 = 0 has no effect. A set in the same cycle as a clear wins.
- R10: Register map (`addr_i`): 0 = divider, 1 = interval, 2 = status {bit 1 enable, bit 0 interrupt flag, others 0}, 3 = reserved and reads 0. Reads are combinational and `irq_o` mirrors the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| prst_cnt_zero_i | input | 1 | High when the periodic-reset count is zero |
| irq_o | output | 1 | Sticky wake-up interrupt flag |

## Verification
The in-RTL assertions check the following on every cycle:

- The prescaler never reaches its period.
- The interrupt flag rises only on an enabled tick.
- The flag holds until cleared.
- Accepted zero writes disable the interrupt.
- Refused zero writes leave the register and enable stable.

Exact interrupt timing can only be shown by bench scenarios that count edges against expected `P×N` values. These scenarios cover restart versus same-value rewrite, a divider change taking effect at the next tick boundary, and re-enabling after a disable.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    A_DIV  = 2'd0,
    A_INT  = 2'd1,
    A_STAT = 2'd2,
    A_RSVD = 2'd3
  } pwu_addr_e;

  localparam logic [REG_W-1:0] DIV_RST = 8'h1F;
  localparam logic [REG_W-1:0] INT_RST = 8'hFF;
endpackage

// File: rtl/pwu_regs.sv
module pwu_regs
  import pwu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             prst_cnt_zero_i,
  input  logic             irq_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [REG_W-1:0] div_o,
  output logic [REG_W-1:0] int_o,
  output logic             en_o,
  output logic             restart_o,
  output logic             clr_o
);
  logic [REG_W-1:0] div_q, int_q;
  logic             en_q;
  logic             wr_div, wr_int, wr_zero;

  assign wr_div  = wr_en_i && (addr_i == A_DIV);
  assign wr_int  = wr_en_i && (addr_i == A_INT);
  assign wr_zero = wr_int && (wdata_i == '0);

  // changed or re-enabling value restarts; accepted zero also restarts
  always_comb begin
    restart_o = 1'b0;
    if (wr_int) begin
      if (wdata_i == '0) restart_o = !prst_cnt_zero_i;
      else               restart_o = (wdata_i != int_q) || !en_q;
    end
  end

  assign clr_o = wr_en_i && (addr_i == A_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= DIV_RST;
      int_q <= INT_RST;
      en_q  <= 1'b1;
    end else begin
      if (wr_div) div_q <= wdata_i;
      if (wr_int && restart_o) begin
        if (wdata_i == '0) begin
          int_q <= INT_RST;
          en_q  <= 1'b0;
        end else begin
          int_q <= wdata_i;
          en_q  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_DIV:   rdata_o = div_q;
      A_INT:   rdata_o = int_q;
      A_STAT:  rdata_o = {{(REG_W-2){1'b0}}, en_q, irq_i};
      default: rdata_o = '0;
    endcase
  end

  assign div_o = div_q;
  assign int_o = int_q;
  assign en_o  = en_q;

  a_r6_zero_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_zero && !prst_cnt_zero_i) |=> (int_q == INT_RST && !en_q));

  a_r7_zero_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_zero && prst_cnt_zero_i) |=> ($stable(int_q) && $stable(en_q)));
endmodule

// File: rtl/pwu_tick_gen.sv
module pwu_tick_gen
  import pwu_pkg::*;
#(
  parameter int BASE_CYC = 504,
  parameter int STEP_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int MAX_PER = BASE_CYC + STEP_CYC * ((1 << REG_W) - 1);
  localparam int PER_W   = $clog2(MAX_PER + 1);

  logic [REG_W-1:0] div_act_q;
  logic [PER_W-1:0] cnt_q, period;

  assign period = PER_W'(BASE_CYC) + PER_W'(STEP_CYC) * PER_W'(div_act_q);
  assign tick_o = !restart_i && (cnt_q == period - PER_W'(1));

  // divider latched only at tick boundary or restart
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      div_act_q <= DIV_RST;
    end else if (restart_i || tick_o) begin
      cnt_q     <= '0;
      div_act_q <= div_i;
    end else begin
      cnt_q <= cnt_q + PER_W'(1);
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period);
endmodule

// File: rtl/pwu_interval_cnt.sv
module pwu_interval_cnt
  import pwu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [REG_W-1:0] int_i,
  input  logic             en_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic [REG_W-1:0] tcnt_q;
  logic             hit;

  assign hit = tick_i && (tcnt_q == int_i - REG_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt_q <= '0;
    end else if (restart_i || hit) begin
      tcnt_q <= '0;
    end else if (tick_i) begin
      tcnt_q <= tcnt_q + REG_W'(1);
    end
  end

  // set wins over same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              irq_o <= 1'b0;
    else if (hit && en_i)     irq_o <= 1'b1;
    else if (clr_i)           irq_o <= 1'b0;
  end

  a_r3_irq_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i && en_i));

  a_r9_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_i) |=> irq_o);
endmodule

// File: rtl/pwu_timer.sv
module pwu_timer
  import pwu_pkg::*;
#(
  parameter int BASE_CYC = 504,
  parameter int STEP_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       prst_cnt_zero_i,
  output logic       irq_o
);
  logic [REG_W-1:0] div, intv;
  logic             en, restart, clr, tick, irq;

  pwu_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .prst_cnt_zero_i,
    .irq_i(irq), .rdata_o, .div_o(div), .int_o(intv), .en_o(en),
    .restart_o(restart), .clr_o(clr)
  );

  pwu_tick_gen #(.BASE_CYC(BASE_CYC), .STEP_CYC(STEP_CYC)) u_tick (
    .clk_i, .rst_ni, .div_i(div), .restart_i(restart), .tick_o(tick)
  );

  pwu_interval_cnt u_icnt (
    .clk_i, .rst_ni, .tick_i(tick), .restart_i(restart), .int_i(intv),
    .en_i(en), .clr_i(clr), .irq_o(irq)
  );

  assign irq_o = irq;
endmodule

// File: tb/pwu_timer_tb.sv
module pwu_timer_tb;
  localparam int BASE = 4;
  localparam int STEP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       prst_zero = 1'b0;
  logic       irq;

  int n_run = 0, n_fail = 0;
  int cur_int;

  always #5 clk = ~clk;

  pwu_timer #(.BASE_CYC(BASE), .STEP_CYC(STEP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .prst_cnt_zero_i(prst_zero), .irq_o(irq)
  );

  function automatic int per(input int d);
    return BASE + STEP * d;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1 v = int'(rdata);
  endtask

  // irq expected on the k-th edge after return of the last write
  task automatic expect_irq(input string req, input int k);
    repeat (k - 1) @(posedge clk);
    #1 chk(req, int'(irq), 0);
    @(posedge clk);
    #1 chk(req, int'(irq), 1);
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd20240611));
    #22;
    rd(2'd0, v); chk("R1 div reset", v, 8'h1F);
    rd(2'd1, v); chk("R3 int reset", v, 8'hFF);
    rd(2'd2, v); chk("R10 status reset", v, 2);
    chk("R3 irq reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    expect_irq("R3 first irq after reset", per(31) * 255);
    rd(2'd3, v); chk("R10 reserved", v, 0);
    wr(2'd2, 8'h00); chk("R9 write 0 keeps", int'(irq), 1);
    wr(2'd2, 8'h01); chk("R9 w1c", int'(irq), 0);

    // divider readback, then restart with div 0
    wr(2'd0, 8'hA5); rd(2'd0, v); chk("R1 readback", v, 8'hA5);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'd4); cur_int = 4;
    repeat (5) @(posedge clk);
    wr(2'd1, 8'd4);  // same value at edge 6
    expect_irq("R5 same value ignored", 16 - 6);
    wr(2'd2, 8'h01);

    wr(2'd1, 8'd3);
    repeat (4) @(posedge clk);
    wr(2'd1, 8'd2); cur_int = 2;
    expect_irq("R4 changed value restarts", per(0) * 2);
    wr(2'd2, 8'h01);

    // refused zero
    prst_zero = 1'b1;
    wr(2'd1, 8'd5); cur_int = 5;
    repeat (6) @(posedge clk);
    wr(2'd1, 8'd0);
    rd(2'd1, v); chk("R7 int kept", v, 5);
    rd(2'd2, v); chk("R7 enable kept", v & 2, 2);
    expect_irq("R7 count undisturbed", 20 - 7);
    wr(2'd2, 8'h01);

    // accepted zero
    prst_zero = 1'b0;
    wr(2'd1, 8'd0);
    rd(2'd1, v); chk("R6 int forced FF", v, 8'hFF);
    rd(2'd2, v); chk("R6 enable cleared", v, 0);
    repeat (1100) @(posedge clk);
    #1 chk("R6 no irq while disabled", int'(irq), 0);
    wr(2'd1, 8'hFF); cur_int = 255;
    rd(2'd2, v); chk("R8 re-enabled", v & 2, 2);
    expect_irq("R8 restart on re-enable", per(0) * 255);
    wr(2'd2, 8'h01);

    // divider change applies at next tick boundary
    wr(2'd1, 8'd2); cur_int = 2;
    wr(2'd0, 8'd3);
    expect_irq("R2 div at tick boundary", per(0) + per(3) - 1);
    rd(2'd0, v); chk("R1 div readback", v, 3);
    wr(2'd2, 8'h01);

    for (int i = 0; i < 12; i++) begin
      int d, n;
      d = int'($urandom % 8);
      n = 1 + int'($urandom % 6);
      if (n == cur_int) n = (n == 6) ? 1 : n + 1;
      wr(2'd0, 8'(d));
      wr(2'd1, 8'(n)); cur_int = n;
      expect_irq("R2 R3 random period", per(d) * n);
      wr(2'd2, 8'h01);
      chk("R9 random clear", int'(irq), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule